// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block gathers a set of event inputs and one software-generated event into sticky status bits. Every status bit can be cleared by writing a one to it, and can be kept away from the request pin by a mask bit that must be set to 1 to enable it. Firmware reaches all of this through a plain register port with address, write strobe, write data and combinational read data.

The unmasked status drives a single interrupt request pin. The pin can be left undriven, behave as an open-drain active-low line, or be driven as an active-low or active-high output. It comes out of reset undriven and stays that way until firmware picks an output mode. A duration field makes the request either a fixed-length pulse or a level that holds until the pending bits are cleared or masked. The live level of every event input can also be read back, and that copy is never latched, cleared or masked.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the configuration (offset 0), status (offset 2) and mask (offset 4) registers read 0, and `irq_oe` is 0, so the pin is undriven.
- R2: A 0-to-1 transition on `evt_in[i]` sets status bit i at the next clock edge. An input held high does not set its bit again once that bit has been cleared.
- R3: Writing offset 3 clears every status bit whose data bit is 1 and leaves the other bits unchanged. When a set and a clear of the same bit fall in one cycle, the bit ends up set.
- R4: The mask register (offset 4) reads back what was written. A status bit reaches the request only while its mask bit is 1.
- R5: Writing 1 to data bit 0 at offset 5 sets status bit N_EVT, the software event. That bit is cleared and masked like any other.
- R6: Offset 1 returns the live `evt_in` levels in bits N_EVT-1:0. Clears and masks do not affect it.
- R7: Reads of offsets 3 and 5, which are write-only, return 0.
- R8: Configuration bits 3:2 set the duration. Codes 0, 1 and 2 give a pulse of 3, 15 or 63 clock cycles, which starts one cycle after the status bit is set.
- R9: Duration code 3 holds the request active for as long as any unmasked status bit is set.
- R10: In pulse mode, a status bit that stays set produces no further pulse. A further unmasked status bit that becomes set starts a new pulse of full length.
- R11: Configuration bits 1:0 select the pin mode: 0 leaves it undriven, 1 is open-drain active low (drives 0 only while active), 2 drives the inverse of active, and 3 drives active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | N_EVT+1 | Write data |
| bus_rdata | output | N_EVT+1 | Read data for `bus_addr` (combinational) |
| evt_in | input | N_EVT | Event condition inputs |
| irq_oe | output | 1 | Pin output enable; 0 means high impedance |
| irq_out | output | 1 | Pin level whenever `irq_oe` is 1 |

## Verification
On every cycle the assertions check four things: the pin is undriven straight after reset, an input edge always reaches its status bit, a status bit never drops without a clear, and an open-drain pin never drives high. They also check that the write-only offsets read zero and that the request is idle in level mode when nothing unmasked is pending. Only the bench scenarios can show the exact pulse lengths for each duration code. The same holds for the absence of a repeat pulse while a bit stays set, the fresh pulse when another bit arrives, and the pin levels across every mode and request state.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int ADDR_W = 3;
    localparam int CNT_W  = 6;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_RAW  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd4;
    localparam logic [ADDR_W-1:0] A_SOFT = 3'd5;

    typedef enum logic [1:0] {
        PIN_HIZ      = 2'd0,
        PIN_OD_LOW   = 2'd1,
        PIN_DRV_LOW  = 2'd2,
        PIN_DRV_HIGH = 2'd3
    } pin_mode_e;

    typedef enum logic [1:0] {
        DUR_3    = 2'd0,
        DUR_15   = 2'd1,
        DUR_63   = 2'd2,
        DUR_HOLD = 2'd3
    } dur_e;

    typedef struct packed {
        dur_e      dur;
        pin_mode_e mode;
    } irq_cfg_t;

    // Pulse length 4^(code+1) - 1: 3, 15, 63
    function automatic logic [CNT_W-1:0] pulse_len(dur_e d);
        int unsigned n;
        n = (32'd4 << (2 * int'(d))) - 32'd1;
        return n[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/evt_latch.sv
module evt_latch #(
    parameter int N_EVT = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] evt_in,
    input  logic             soft_set,
    input  logic [N_EVT:0]   clr_vec,
    output logic [N_EVT:0]   status
);
    logic [N_EVT-1:0] evt_q;
    logic [N_EVT:0]   set_vec;

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt_in;
    end

    always_comb set_vec = {soft_set, evt_in & ~evt_q};

    for (genvar b = 0; b <= N_EVT; b++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)               bit_q <= 1'b0;
            else if (set_vec[b])   bit_q <= 1'b1;
            else if (clr_vec[b])   bit_q <= 1'b0;
        end
        assign status[b] = bit_q;
    end
endmodule

// File: rtl/irq_timer.sv
module irq_timer
    import evt_irq_pkg::*;
#(
    parameter int NS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  dur_e          dur,
    input  logic [NS-1:0] pend,
    output logic          active
);
    logic [NS-1:0]    pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic             trig;

    always_comb trig = |(pend & ~pend_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            cnt_q  <= '0;
        end else begin
            pend_q <= pend;
            if (trig)            cnt_q <= pulse_len(dur);
            else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb active = (dur == DUR_HOLD) ? (|pend) : (cnt_q != '0);
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
    import evt_irq_pkg::*;
(
    input  pin_mode_e mode,
    input  logic      active,
    output logic      pin_oe,
    output logic      pin_out
);
    always_comb begin
        pin_oe  = 1'b0;
        pin_out = 1'b0;
        case (mode)
            PIN_OD_LOW:   begin pin_oe = active; pin_out = 1'b0;    end
            PIN_DRV_LOW:  begin pin_oe = 1'b1;   pin_out = ~active; end
            PIN_DRV_HIGH: begin pin_oe = 1'b1;   pin_out = active;  end
            default:      begin pin_oe = 1'b0;   pin_out = 1'b0;    end
        endcase
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int N_EVT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wen,
    input  logic [2:0]        bus_addr,
    input  logic [N_EVT:0]    bus_wdata,
    output logic [N_EVT:0]    bus_rdata,
    input  logic [N_EVT-1:0]  evt_in,
    output logic              irq_oe,
    output logic              irq_out
);
    localparam int NS = N_EVT + 1;

    irq_cfg_t        cfg_q;
    logic [NS-1:0]   mask_q;
    logic [NS-1:0]   status_w;
    logic [NS-1:0]   clr_vec;
    logic            soft_set;
    logic            req_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '{dur: DUR_3, mode: PIN_HIZ};
            mask_q <= '0;
        end else if (bus_wen) begin
            if (bus_addr == A_CFG)  cfg_q  <= irq_cfg_t'(bus_wdata[3:0]);
            if (bus_addr == A_MASK) mask_q <= bus_wdata;
        end
    end

    always_comb begin
        clr_vec  = (bus_wen && bus_addr == A_CLR) ? bus_wdata : '0;
        soft_set = bus_wen && (bus_addr == A_SOFT) && bus_wdata[0];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG:   bus_rdata[3:0]       = cfg_q;
            A_RAW:   bus_rdata[N_EVT-1:0] = evt_in;
            A_STAT:  bus_rdata            = status_w;
            A_MASK:  bus_rdata            = mask_q;
            default: bus_rdata            = '0;
        endcase
    end

    evt_latch #(.N_EVT(N_EVT)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .evt_in   (evt_in),
        .soft_set (soft_set),
        .clr_vec  (clr_vec),
        .status   (status_w)
    );

    irq_timer #(.NS(NS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .dur    (cfg_q.dur),
        .pend   (status_w & mask_q),
        .active (req_active)
    );

    irq_pin_drv u_pin (
        .mode    (cfg_q.mode),
        .active  (req_active),
        .pin_oe  (irq_oe),
        .pin_out (irq_out)
    );
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
    import evt_irq_pkg::*;
#(
    parameter int N_EVT = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [N_EVT-1:0] evt_in,
    input logic [N_EVT:0]   status,
    input logic [N_EVT:0]   mask,
    input logic [N_EVT:0]   clr_vec,
    input logic [3:0]       cfg_bits,
    input logic             req_active,
    input logic             bus_wen,
    input logic [2:0]       bus_addr,
    input logic [N_EVT:0]   bus_wdata,
    input logic [N_EVT:0]   bus_rdata,
    input logic             irq_oe,
    input logic             irq_out
);
    logic [N_EVT-1:0] evt_d;
    logic [N_EVT-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) evt_d <= '0;
        else     evt_d <= evt_in;
    end
    always_comb rise = evt_in & ~evt_d;

    a_r1_hiz_after_reset: assert property (@(posedge clk)
        $past(rst) && !rst |-> !irq_oe);

    a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((status[N_EVT-1:0] & $past(rise)) == $past(rise)));

    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((($past(status) & ~$past(clr_vec)) & ~status) == '0));

    a_r4_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (cfg_bits[3:2] == DUR_HOLD && (status & mask) == '0) |-> !req_active);

    a_r5_soft_sets: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == A_SOFT && bus_wdata[0]) |=> status[N_EVT]);

    a_r7_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_CLR || bus_addr == A_SOFT) |-> bus_rdata == '0);

    a_r11_od_never_high: assert property (@(posedge clk) disable iff (rst)
        (cfg_bits[1:0] == PIN_OD_LOW && irq_oe) |-> !irq_out);

    a_r11_hiz_undriven: assert property (@(posedge clk) disable iff (rst)
        (cfg_bits[1:0] == PIN_HIZ) |-> !irq_oe);
endmodule

bind evt_irq_ctrl evt_irq_chk #(.N_EVT(N_EVT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_in     (evt_in),
    .status     (status_w),
    .mask       (mask_q),
    .clr_vec    (clr_vec),
    .cfg_bits   (cfg_q),
    .req_active (req_active),
    .bus_wen    (bus_wen),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_oe     (irq_oe),
    .irq_out    (irq_out)
);

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;
    import evt_irq_pkg::*;

    localparam int N_EVT = 7;
    localparam int NS    = N_EVT + 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wen = 1'b0;
    logic [2:0]      bus_addr = '0;
    logic [NS-1:0]   bus_wdata = '0;
    logic [NS-1:0]   bus_rdata;
    logic [N_EVT-1:0] evt_in = '0;
    logic            irq_oe, irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    evt_irq_ctrl #(.N_EVT(N_EVT)) uut (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .irq_oe(irq_oe), .irq_out(irq_out)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [NS-1:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic set_evt(int i, logic v);
        @(negedge clk);
        evt_in[i] = v;
    endtask

    task automatic count_high(int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1 if (irq_out) c++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        int c;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(A_CFG, v);  check("R1 cfg", v, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_MASK, v); check("R1 mask", v, 0);
        check("R1 oe", int'(irq_oe), 0);

        // R2 / R6 per-event sweep
        for (int i = 0; i < N_EVT; i++) begin
            set_evt(i, 1'b1);
            rd(A_STAT, v); check("R2 set on edge", v, 1 << i);
            rd(A_RAW, v);  check("R6 raw live", v, 1 << i);
            wr(A_CLR, NS'(1 << i));
            rd(A_STAT, v); check("R2 no re-set while high", v, 0);
            rd(A_RAW, v);  check("R6 raw after clear", v, 1 << i);
            set_evt(i, 1'b0);
            rd(A_RAW, v);  check("R6 raw low", v, 0);
        end

        // R3 selective clear
        for (int i = 0; i < 4; i++) set_evt(i, 1'b1);
        rd(A_STAT, v); check("R3 four set", v, 'hF);
        wr(A_CLR, 8'h05);
        rd(A_STAT, v); check("R3 selective clear", v, 'hA);
        wr(A_CLR, 8'hFF);
        rd(A_STAT, v); check("R3 clear all", v, 0);
        for (int i = 0; i < 4; i++) set_evt(i, 1'b0);
        // R3 set wins over simultaneous clear
        @(negedge clk);
        evt_in[2] = 1'b1;
        bus_wen = 1'b1; bus_addr = A_CLR; bus_wdata = 8'h04;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
        rd(A_STAT, v); check("R3 set wins", v, 'h04);
        wr(A_CLR, 8'hFF);
        set_evt(2, 1'b0);

        // R5 software event, R7 write-only reads
        wr(A_SOFT, 8'h00);
        rd(A_STAT, v); check("R5 soft zero no effect", v, 0);
        wr(A_SOFT, 8'h01);
        rd(A_STAT, v); check("R5 soft sets", v, 1 << N_EVT);
        rd(A_CLR, v);  check("R7 clear reads zero", v, 0);
        rd(A_SOFT, v); check("R7 soft reads zero", v, 0);
        wr(A_CLR, NS'(1 << N_EVT));
        rd(A_STAT, v); check("R5 soft cleared", v, 0);

        // R4 mask read-back sweep
        for (int m = 0; m < (1 << NS); m++) begin
            wr(A_MASK, NS'(m));
            rd(A_MASK, v); check("R4 mask readback", v, m);
        end

        // R4 / R9 level mode, pin driven high
        wr(A_MASK, 8'h00);
        wr(A_CFG, 8'h0F);
        set_evt(3, 1'b1);
        for (int j = 0; j < NS; j++) begin
            wr(A_MASK, NS'(1 << j));
            #1 check("R4 mask gating", int'(irq_out), (j == 3) ? 1 : 0);
        end
        wr(A_MASK, 8'h08);
        count_high(100, c); check("R9 level holds", c, 100);
        wr(A_CLR, 8'h08);
        #1 check("R9 level drops on clear", int'(irq_out), 0);

        // R11 pin modes with active and idle request
        for (int a = 0; a < 2; a++) begin
            for (int md = 0; md < 4; md++) begin
                int eoe;
                int eout;
                wr(A_CFG, NS'(12 + md));
                if (a == 1) begin
                    wr(A_SOFT, 8'h01); wr(A_MASK, 8'h80);
                end else begin
                    wr(A_MASK, 8'h00);
                end
                eoe  = (md == 0) ? 0 : (md == 1) ? a : 1;
                eout = (md == 3) ? a : (md == 2) ? 1 - a : 0;
                #1;
                check("R11 oe", int'(irq_oe), eoe);
                check("R11 out", int'(irq_out), eout);
            end
        end
        set_evt(3, 1'b0);

        // R8 / R10 pulse durations
        for (int d = 0; d < 3; d++) begin
            wr(A_CFG, NS'(d * 4 + 3));
            wr(A_CLR, 8'hFF);
            wr(A_MASK, 8'hFF);
            repeat (70) @(negedge clk);
            wr(A_SOFT, 8'h01);
            count_high(100, c);
            check("R8 pulse length", c, (4 << (2 * d)) - 1);
            check("R10 no repeat while set", c, (4 << (2 * d)) - 1);
        end
        wr(A_CFG, 8'h07);
        wr(A_CLR, 8'hFF);
        repeat (70) @(negedge clk);
        wr(A_SOFT, 8'h01);
        count_high(40, c); check("R8 first pulse 15", c, 15);
        set_evt(0, 1'b1);
        count_high(40, c); check("R10 new bit new pulse", c, 15);
        set_evt(0, 1'b0);

        finish_run();
    end
endmodule